// File: doc/BRIEF.md
# Decode Operand Forwarding Selector

This block sits in front of the decode-to-execute pipeline register of a five-stage in-order core and picks the two operand values that the instruction now in decode carries into execute. Each operand has a source register ID. The block compares that ID with the destination ID of each result still in flight: the combinational output of execute, the memory-stage register and the writeback-stage register. When an ID matches, the block passes that stage's value forward in place of the register file read.

It is purely combinational. Because the youngest matching result always wins, a chain of dependent register moves and ALU operations runs back to back without a stall. That includes an instruction that reads the result of the instruction just before it. The ID 0xF means "no register". A conditional move whose condition failed leaves execute with destination 0xF, so it drops out of the comparison on its own.

Top module: `fwd_operand_forward`

## Requirements
- R1: When an operand's source ID is not 0xF and equals `ex_dst_i`, that operand output equals `ex_val_i`.
- R2: When the source ID is not 0xF, does not equal `ex_dst_i`, and equals `mem_dst_i`, the output equals `mem_val_i`.
- R3: When the source ID is not 0xF, matches neither `ex_dst_i` nor `mem_dst_i`, and equals `wb_dst_i`, the output equals `wb_val_i`.
- R4: When a source ID matches none of the three destination IDs, the output equals that operand's register file read data.
- R5: When several stages match, the priority is fixed: execute, then memory, then writeback.
- R6: A source ID of 0xF never forwards. The output is the register file data even when some destination ID is also 0xF.
- R7: A stage whose destination is 0xF never supplies a value, for example a failed conditional move. The next older matching stage, or the register file, is used instead.
- R8: Operands A and B are selected independently. Both may forward from the same stage in the same cycle.
- R9: In a five-stage pipeline whose register file is written at the end of writeback, back-to-back dependent immediate loads and register copies leave every register with the value that sequential execution of the program would give. Both register-copy test programs are checked this way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_i | input | 4 | Source register ID of operand A (0xF = none) |
| src_b_i | input | 4 | Source register ID of operand B (0xF = none) |
| rf_a_i | input | 64 | Register file read data for operand A |
| rf_b_i | input | 64 | Register file read data for operand B |
| ex_dst_i | input | 4 | Destination ID leaving execute |
| ex_val_i | input | 64 | Value computed in execute |
| mem_dst_i | input | 4 | Destination ID held in the memory-stage register |
| mem_val_i | input | 64 | Value held in the memory-stage register |
| wb_dst_i | input | 4 | Destination ID held in the writeback-stage register |
| wb_val_i | input | 64 | Value held in the writeback-stage register |
| val_a_o | output | 64 | Selected operand A |
| val_b_o | output | 64 | Selected operand B |

## Verification
The immediate assertions assume the inputs are stable when they are evaluated. Each one checks only the resolved selection against the input port values, so they rely only on the data and ID ports being well defined.

The random stimulus draws source and destination IDs from a small pool that includes 0xF. This makes multi-stage collisions and the "no register" code common. All inputs are changed together and the outputs are only examined after a settling delay.

A small pipeline model in the bench keeps the operands consistent with real instruction flow: a stage holds a destination only while a real writer occupies it. It then checks the register contents at the end of the program.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  parameter int unsigned DATA_W = 64;
  parameter int unsigned REG_W  = 4;

  // index 0 is the youngest in-flight result
  typedef enum int unsigned {
    STG_EX  = 0,
    STG_MEM = 1,
    STG_WB  = 2,
    NUM_STG = 3
  } fwd_stage_e;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int unsigned REG_W = 4
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] dst_i,
  output logic             hit_o
);
  localparam logic [REG_W-1:0] REG_NONE = '1;

  assign hit_o = (src_i != REG_NONE) && (src_i == dst_i);
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned REG_W  = 4,
  parameter int unsigned N_STG  = 3
) (
  input  logic [REG_W-1:0]             src_i,
  input  logic [DATA_W-1:0]            rf_i,
  input  logic [N_STG-1:0][REG_W-1:0]  dst_i,
  input  logic [N_STG-1:0][DATA_W-1:0] val_i,
  output logic [DATA_W-1:0]            val_o
);
  logic [N_STG-1:0]             hit;
  logic [N_STG:0][DATA_W-1:0]   chain;

  assign chain[N_STG] = rf_i;

  // older stages sit deeper in the chain; youngest hit wins
  for (genvar i = 0; i < N_STG; i++) begin : g_stage
    fwd_hit #(.REG_W(REG_W)) u_hit (
      .src_i (src_i),
      .dst_i (dst_i[i]),
      .hit_o (hit[i])
    );
    assign chain[i] = hit[i] ? val_i[i] : chain[i+1];
  end

  assign val_o = chain[0];
endmodule

// File: rtl/fwd_operand_forward.sv
module fwd_operand_forward
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = fwd_pkg::DATA_W,
  parameter int unsigned REG_W  = fwd_pkg::REG_W
) (
  input  logic [REG_W-1:0]  src_a_i,
  input  logic [REG_W-1:0]  src_b_i,
  input  logic [DATA_W-1:0] rf_a_i,
  input  logic [DATA_W-1:0] rf_b_i,
  input  logic [REG_W-1:0]  ex_dst_i,
  input  logic [DATA_W-1:0] ex_val_i,
  input  logic [REG_W-1:0]  mem_dst_i,
  input  logic [DATA_W-1:0] mem_val_i,
  input  logic [REG_W-1:0]  wb_dst_i,
  input  logic [DATA_W-1:0] wb_val_i,
  output logic [DATA_W-1:0] val_a_o,
  output logic [DATA_W-1:0] val_b_o
);
  localparam int unsigned N_STG = int'(NUM_STG);
  localparam logic [REG_W-1:0] REG_NONE = '1;

  logic [N_STG-1:0][REG_W-1:0]  stg_dst;
  logic [N_STG-1:0][DATA_W-1:0] stg_val;

  assign stg_dst[STG_EX]  = ex_dst_i;
  assign stg_val[STG_EX]  = ex_val_i;
  assign stg_dst[STG_MEM] = mem_dst_i;
  assign stg_val[STG_MEM] = mem_val_i;
  assign stg_dst[STG_WB]  = wb_dst_i;
  assign stg_val[STG_WB]  = wb_val_i;

  logic [1:0][REG_W-1:0]  op_src;
  logic [1:0][DATA_W-1:0] op_rf;
  logic [1:0][DATA_W-1:0] op_val;

  assign op_src = {src_b_i, src_a_i};
  assign op_rf  = {rf_b_i, rf_a_i};

  for (genvar k = 0; k < 2; k++) begin : g_op
    fwd_operand_sel #(
      .DATA_W (DATA_W),
      .REG_W  (REG_W),
      .N_STG  (N_STG)
    ) u_sel (
      .src_i (op_src[k]),
      .rf_i  (op_rf[k]),
      .dst_i (stg_dst),
      .val_i (stg_val),
      .val_o (op_val[k])
    );
  end

  assign val_a_o = op_val[0];
  assign val_b_o = op_val[1];

  always_comb begin
    if (src_a_i != REG_NONE && src_a_i == ex_dst_i)
      assert_ex_first_R1: assert (val_a_o == ex_val_i);
    if (src_a_i != REG_NONE && src_a_i != ex_dst_i && src_a_i == mem_dst_i)
      assert_mem_second_R2: assert (val_a_o == mem_val_i);
    if (src_a_i != REG_NONE && src_a_i != ex_dst_i && src_a_i != mem_dst_i
        && src_a_i == wb_dst_i)
      assert_wb_third_R3: assert (val_a_o == wb_val_i);
    if (src_a_i != ex_dst_i && src_a_i != mem_dst_i && src_a_i != wb_dst_i)
      assert_rf_default_R4: assert (val_a_o == rf_a_i);
    if (src_a_i == REG_NONE)
      assert_none_src_a_R6: assert (val_a_o == rf_a_i);
    if (src_b_i == REG_NONE)
      assert_none_src_b_R6: assert (val_b_o == rf_b_i);
    if (src_b_i != REG_NONE && src_b_i == ex_dst_i)
      assert_b_indep_R8: assert (val_b_o == ex_val_i);
  end
endmodule

// File: tb/tb_fwd_operand_forward.sv
module tb_fwd_operand_forward;
  localparam logic [3:0] NONE = 4'hF;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  src_a, src_b, ex_dst, mem_dst, wb_dst;
  logic [63:0] rf_a, rf_b, ex_val, mem_val, wb_val, val_a, val_b;

  fwd_operand_forward dut (
    .src_a_i(src_a), .src_b_i(src_b), .rf_a_i(rf_a), .rf_b_i(rf_b),
    .ex_dst_i(ex_dst), .ex_val_i(ex_val), .mem_dst_i(mem_dst),
    .mem_val_i(mem_val), .wb_dst_i(wb_dst), .wb_val_i(wb_val),
    .val_a_o(val_a), .val_b_o(val_b)
  );

  int total = 0;
  int bad = 0;

  function automatic logic [63:0] exp_sel(input logic [3:0] s, input logic [63:0] rf);
    if (s == NONE)    return rf;
    if (s == ex_dst)  return ex_val;
    if (s == mem_dst) return mem_val;
    if (s == wb_dst)  return wb_val;
    return rf;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] sa, input logic [3:0] sb,
                       input logic [3:0] de, input logic [3:0] dm, input logic [3:0] dw);
    src_a = sa; src_b = sb; ex_dst = de; mem_dst = dm; wb_dst = dw;
    rf_a = {$urandom, $urandom}; rf_b = {$urandom, $urandom};
    ex_val = {$urandom, $urandom}; mem_val = {$urandom, $urandom};
    wb_val = {$urandom, $urandom};
    #1;
  endtask

  task automatic both(input string req);
    chk({req, " A"}, val_a, exp_sel(src_a, rf_a));
    chk({req, " B"}, val_b, exp_sel(src_b, rf_b));
  endtask

  // --- pipeline model for R9 ---
  typedef struct packed { logic ir; logic [3:0] src; logic [3:0] dst; logic [63:0] imm; } ins_t;
  ins_t prog [8];
  int   plen;
  logic [63:0] rf [16];

  task automatic run_prog(input string req);
    logic [63:0] ref_rf [16];
    logic [3:0]  e_dst, m_dst, w_dst;
    logic [63:0] e_imm, e_va, m_val, w_val, ev, va;
    logic        e_ir;
    ins_t        d;
    for (int i = 0; i < 16; i++) begin rf[i] = 64'd0; ref_rf[i] = 64'd0; end
    for (int i = 0; i < plen; i++)
      ref_rf[prog[i].dst] = prog[i].ir ? prog[i].imm : ref_rf[prog[i].src];
    e_dst = NONE; m_dst = NONE; w_dst = NONE;
    e_imm = 0; e_va = 0; m_val = 0; w_val = 0; e_ir = 0;
    for (int c = 0; c < plen + 4; c++) begin
      @(negedge clk);
      d = (c < plen) ? prog[c] : '{ir: 1'b0, src: NONE, dst: NONE, imm: 64'd0};
      ev = e_ir ? e_imm : e_va;
      src_a = d.ir ? NONE : d.src; src_b = NONE;
      rf_a = rf[src_a]; rf_b = 64'd0;
      ex_dst = e_dst; ex_val = ev; mem_dst = m_dst; mem_val = m_val;
      wb_dst = w_dst; wb_val = w_val;
      #1 va = val_a;
      @(posedge clk);
      if (w_dst != NONE) rf[w_dst] = w_val;
      w_dst = m_dst; w_val = m_val;
      m_dst = e_dst; m_val = ev;
      e_dst = d.dst; e_ir = d.ir; e_imm = d.imm; e_va = va;
    end
    for (int i = 0; i < 15; i++) chk(req, rf[i], ref_rf[i]);
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    drive(NONE, NONE, NONE, NONE, NONE);
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // reset/idle state: nothing in flight
    chk("R4 idle A", val_a, rf_a);
    // directed
    drive(4'd3, 4'd5, 4'd3, 4'd3, 4'd3);  chk("R1/R5 A", val_a, ex_val);  chk("R4 B", val_b, rf_b);
    drive(4'd2, 4'd2, 4'd1, 4'd2, 4'd2);  chk("R2/R5 A", val_a, mem_val); chk("R8 B", val_b, mem_val);
    drive(4'd7, 4'd0, 4'd1, 4'd2, 4'd7);  chk("R3 A", val_a, wb_val);     chk("R4 B", val_b, rf_b);
    drive(NONE, NONE, NONE, NONE, NONE);  chk("R6 A", val_a, rf_a);       chk("R6 B", val_b, rf_b);
    drive(4'd4, 4'd4, NONE, 4'd4, 4'd9);  chk("R7 A", val_a, mem_val);    chk("R7 B", val_b, mem_val);
    drive(4'd6, 4'd6, NONE, NONE, NONE);  chk("R7 rf A", val_a, rf_a);
    drive(4'd1, 4'd1, 4'd1, 4'd1, 4'd1);  chk("R8 A", val_a, ex_val);     chk("R8 B", val_b, ex_val);
    // random with collision-heavy IDs
    for (int n = 0; n < 400; n++) begin
      logic [3:0] pool [4];
      pool = '{4'd0, 4'd1, 4'd2, NONE};
      drive(pool[$urandom_range(3)], pool[$urandom_range(3)], pool[$urandom_range(3)],
            pool[$urandom_range(3)], pool[$urandom_range(3)]);
      both("R5 rand");
    end
    // R9: copy chain with loads 1,2,3 then moves
    plen = 7;
    prog[0] = '{1'b1, NONE, 4'd0, 64'd1};
    prog[1] = '{1'b1, NONE, 4'd3, 64'd2};
    prog[2] = '{1'b1, NONE, 4'd1, 64'd3};
    prog[3] = '{1'b0, 4'd0, 4'd2, 64'd0};
    prog[4] = '{1'b0, 4'd1, 4'd3, 64'd0};
    prog[5] = '{1'b0, 4'd3, 4'd6, 64'd0};
    prog[6] = '{1'b0, 4'd3, 4'd7, 64'd0};
    run_prog("R9 chain");
    chk("R9 rsi", rf[6], 64'd3);
    chk("R9 rdi", rf[7], 64'd3);
    plen = 4;
    prog[0] = '{1'b1, NONE, 4'd0, 64'd5678};
    prog[1] = '{1'b1, NONE, 4'd1, 64'd34};
    prog[2] = '{1'b0, 4'd0, 4'd2, 64'd0};
    prog[3] = '{1'b0, 4'd1, 4'd0, 64'd0};
    run_prog("R9 swap");
    chk("R9 rax", rf[0], 64'h22);
    chk("R9 rdx", rf[2], 64'h162e);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule